// File: doc/BRIEF.md
# TDM Daisy-Chain Frame Merger

This block lets two converters share one serial TDM data line. Each converter produces four 24-bit channels per frame. The device further down the chain receives the upstream device's four-channel stream on a single-bit chain input. It drives an eight-slot frame on its primary output: its own four channels in the first half of the frame, and the four channels from upstream in the second half. The upstream device uses the secondary output, which carries only its own four channels, and its chain input is tied low.

All logic runs in the bit-clock domain. A frame is 256 bit clocks long and holds eight slots of 32 clocks each. A frame-start pulse aligns an internal position counter. Between pulses the counter wraps by itself. The serial bits that arrive on the chain input during the first half of a frame go into a per-channel buffer, and they are replayed in the second half of the same frame. The four local samples are taken in parallel at each frame boundary and then shifted out MSB first.

Top module: `tdmc_merge`

## Requirements
- R1: When `frm_start` is high at a rising edge, the next cycle is frame position 0. Positions run 0 to 255, slot = position / 32 and bit-in-slot = position % 32. The outputs for position p are present for the whole cycle that follows the edge that entered p.
- R2: On `pri_out`, slots 0, 1, 2 and 3 carry local channels L1 = `loc_smp[23:0]`, R1 = `loc_smp[47:24]`, L2 = `loc_smp[71:48]` and R2 = `loc_smp[95:72]`. Each channel is sent MSB first in bit-in-slot 0 to 23.
- R3: `sec_out` carries the same local data in slots 0 to 3 and is low throughout slots 4 to 7.
- R4: `chain_in` is sampled at the rising edge that ends position p. Bits taken in slot c (c = 0 to 3), bit-in-slot 0 to 23, are replayed in the same order on `pri_out` in slot c+4 of the same frame. A chain input held low gives zeros there.
- R5: Bit-in-slot 24 to 31 of every slot is low on both outputs, whatever arrives on `chain_in`.
- R6: `loc_smp` is taken only at the edge that starts a frame. Changing it later in the frame has no effect on that frame's output.
- R7: Bits that arrive on `chain_in` during slots 4 to 7 and in the pad bits are never output.
- R8: During reset, and after reset until the first `frm_start`, both outputs stay low whatever `chain_in` does.
- R9: If no `frm_start` arrives, the position counter wraps from 255 to 0, starts a new frame and takes `loc_smp` again.
- R10: A `frm_start` in the middle of a frame restarts at position 0. Capture starts over, and the replay slots of the new frame show only bits captured in that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (256 times the frame rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Frame-start pulse, one cycle, just before position 0 |
| loc_smp | input | 96 | Four local 24-bit samples, L1 in the low bits |
| chain_in | input | 1 | Serial stream from the upstream device |
| pri_out | output | 1 | Merged eight-slot output |
| sec_out | output | 1 | Local-only output for the next device down the chain |

## Verification
The frames use several stimulus patterns, each aimed at a different fault:
- Irregular hex patterns expose swapped channels and reversed bit order.
- Dense ones on the local side with alternating bits on the chain side expose pad bits that leak and lanes that shift by one bit.
- A single walking one in the upstream data pins a slot to its exact position.
- A chain input held low confirms that the replay half comes only from captured data.
- Junk driven on the chain input during the pad bits and the second half of the frame shows whether those bits ever reach the output.

Frames are also started by wrap alone and cut short by an early sync pulse, at 60 and at 200 positions. This separates a counter that realigns correctly from one that keeps running, and shows whether a buffer left over from a cut frame is replayed. Local samples are changed mid-frame to show that they are held from the frame boundary. Reset is applied both at start-up and in mid-run, to confirm the outputs stay quiet until a sync pulse arrives.

// File: rtl/tdmc_pkg.sv
package tdmc_pkg;

  localparam int TDMC_SLOT_W = 32;
  localparam int TDMC_DATA_W = 24;
  localparam int TDMC_N_LOC  = 4;

  // What the current bit position carries on the outputs.
  typedef enum logic [1:0] {
    SK_IDLE   = 2'd0,
    SK_PAD    = 2'd1,
    SK_LOCAL  = 2'd2,
    SK_REPLAY = 2'd3
  } slot_kind_e;

endpackage

// File: rtl/tdmc_frame_ctr.sv
module tdmc_frame_ctr #(
  parameter int FRAME_LEN = 256,
  parameter int POS_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  output logic [POS_W-1:0] pos,
  output logic             locked,
  output logic             frame_begin,
  output logic             resync
);

  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic             locked_q;
  logic             at_last;

  assign at_last     = (pos_q == LAST);
  assign frame_begin = frm_start | (locked_q & at_last);
  assign resync      = frm_start & locked_q & ~at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      locked_q <= locked_q | frm_start;
      if (frm_start || at_last) pos_q <= '0;
      else                      pos_q <= pos_q + POS_W'(1);
    end
  end

  assign pos    = pos_q;
  assign locked = locked_q;

  AST_SYNC_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (pos == '0)); // R1

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !frm_start && pos != LAST) |=> (pos == $past(pos) + POS_W'(1))); // R1

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !frm_start && pos == LAST) |=> (pos == '0 && locked)); // R9

endmodule

// File: rtl/tdmc_chain_cap.sv
module tdmc_chain_cap #(
  parameter int N_LOC   = 4,
  parameter int DATA_W  = 24,
  parameter int SLOT_W  = 32,
  parameter int POS_W   = 8,
  parameter int BIT_W   = 5,
  parameter int SLOT_IW = 3,
  parameter int CH_W    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [POS_W-1:0]        pos,
  input  logic                    locked,
  input  logic                    resync,
  input  logic                    chain_in,
  output logic [N_LOC*DATA_W-1:0] cap_data,
  output logic                    cap_valid
);

  // Last position of the capture half of the frame.
  localparam logic [POS_W-1:0] CAP_LAST = POS_W'(N_LOC * SLOT_W - 1);

  // Bit-in-slot to storage index: first bit of a slot is the MSB.
  function automatic logic [BIT_W-1:0] msb_first_idx(input logic [BIT_W-1:0] b);
    return BIT_W'(DATA_W - 1) - b;
  endfunction

  function automatic logic is_payload(input logic [BIT_W-1:0] b);
    return b < BIT_W'(DATA_W);
  endfunction

  logic [SLOT_IW-1:0] slot;
  logic [BIT_W-1:0]   bsel;
  logic [CH_W-1:0]    chan;
  logic               upper_half;
  logic               capture_hit;
  logic [BIT_W-1:0]   wr_idx;
  logic               valid_q;

  assign slot        = pos[POS_W-1:BIT_W];
  assign bsel        = pos[BIT_W-1:0];
  assign upper_half  = slot[SLOT_IW-1];
  assign chan        = slot[CH_W-1:0];
  assign wr_idx      = msb_first_idx(bsel);
  assign capture_hit = locked & ~upper_half & is_payload(bsel);

  genvar c;
  generate
    for (c = 0; c < N_LOC; c++) begin : g_lane
      logic [DATA_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  lane_q <= '0;
        else if (capture_hit && chan == CH_W'(c))    lane_q[wr_idx] <= chain_in;
      end
      assign cap_data[c*DATA_W +: DATA_W] = lane_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               valid_q <= 1'b0;
    else if (resync)                          valid_q <= 1'b0;
    else if (locked && pos == CAP_LAST)       valid_q <= 1'b1;
  end

  assign cap_valid = valid_q;

  AST_RESYNC_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !cap_valid); // R10

  AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && pos == CAP_LAST && !resync) |=> cap_valid); // R4

  AST_BUFFER_FROZEN_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_half && !resync) |=> $stable(cap_data)); // R7

endmodule

// File: rtl/tdmc_slot_mux.sv
module tdmc_slot_mux
  import tdmc_pkg::*;
#(
  parameter int N_LOC   = 4,
  parameter int DATA_W  = 24,
  parameter int POS_W   = 8,
  parameter int BIT_W   = 5,
  parameter int SLOT_IW = 3,
  parameter int CH_W    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [POS_W-1:0]        pos,
  input  logic                    locked,
  input  logic                    frame_begin,
  input  logic [N_LOC*DATA_W-1:0] loc_smp,
  input  logic [N_LOC*DATA_W-1:0] cap_data,
  input  logic                    cap_valid,
  output logic                    pri_out,
  output logic                    sec_out
);

  function automatic logic [BIT_W-1:0] msb_first_idx(input logic [BIT_W-1:0] b);
    return BIT_W'(DATA_W - 1) - b;
  endfunction

  function automatic slot_kind_e classify(input logic lk, input logic upper,
                                          input logic [BIT_W-1:0] b);
    if (!lk)                    return SK_IDLE;
    if (b >= BIT_W'(DATA_W))    return SK_PAD;
    if (upper)                  return SK_REPLAY;
    return SK_LOCAL;
  endfunction

  logic [N_LOC*DATA_W-1:0] loc_hold;
  logic [DATA_W-1:0]       loc_ch [N_LOC];
  logic [DATA_W-1:0]       rep_ch [N_LOC];
  logic [SLOT_IW-1:0]      slot;
  logic [BIT_W-1:0]        bsel;
  logic [CH_W-1:0]         chan;
  logic [BIT_W-1:0]        rd_idx;
  logic                    loc_bit;
  logic                    rep_bit;
  slot_kind_e              kind;

  // Local samples are held for the whole frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           loc_hold <= '0;
    else if (frame_begin) loc_hold <= loc_smp;
  end

  genvar c;
  generate
    for (c = 0; c < N_LOC; c++) begin : g_unpack
      assign loc_ch[c] = loc_hold[c*DATA_W +: DATA_W];
      assign rep_ch[c] = cap_data[c*DATA_W +: DATA_W];
    end
  endgenerate

  assign slot    = pos[POS_W-1:BIT_W];
  assign bsel    = pos[BIT_W-1:0];
  assign chan    = slot[CH_W-1:0];
  assign rd_idx  = msb_first_idx(bsel);
  assign kind    = classify(locked, slot[SLOT_IW-1], bsel);
  assign loc_bit = loc_ch[chan][rd_idx];
  assign rep_bit = rep_ch[chan][rd_idx];

  always_comb begin
    pri_out = 1'b0;
    sec_out = 1'b0;
    unique case (kind)
      SK_LOCAL:  begin pri_out = loc_bit; sec_out = loc_bit; end
      SK_REPLAY: pri_out = cap_valid & rep_bit;
      default:   ;
    endcase
  end

  AST_PAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bsel >= BIT_W'(DATA_W)) |-> (!pri_out && !sec_out)); // R5

  AST_SEC_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slot[SLOT_IW-1] |-> !sec_out); // R3

  AST_LOWER_HALF_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    !slot[SLOT_IW-1] |-> (pri_out == sec_out)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!pri_out && !sec_out)); // R8

  AST_LOCAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_begin |=> $stable(loc_hold)); // R6

endmodule

// File: rtl/tdmc_merge.sv
module tdmc_merge
  import tdmc_pkg::*;
#(
  parameter int SLOT_W = TDMC_SLOT_W,
  parameter int DATA_W = TDMC_DATA_W,
  parameter int N_LOC  = TDMC_N_LOC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_start,
  input  logic [N_LOC*DATA_W-1:0] loc_smp,
  input  logic                    chain_in,
  output logic                    pri_out,
  output logic                    sec_out
);

  // Power-of-two slot width and channel count keep slot and bit fields plain slices.
  localparam int N_SLOT    = 2 * N_LOC;
  localparam int FRAME_LEN = N_SLOT * SLOT_W;
  localparam int BIT_W     = $clog2(SLOT_W);
  localparam int CH_W      = $clog2(N_LOC);
  localparam int SLOT_IW   = CH_W + 1;
  localparam int POS_W     = BIT_W + SLOT_IW;

  logic [POS_W-1:0]        pos;
  logic                    locked;
  logic                    frame_begin;
  logic                    resync;
  logic [N_LOC*DATA_W-1:0] cap_data;
  logic                    cap_valid;

  tdmc_frame_ctr #(
    .FRAME_LEN (FRAME_LEN),
    .POS_W     (POS_W)
  ) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_start   (frm_start),
    .pos         (pos),
    .locked      (locked),
    .frame_begin (frame_begin),
    .resync      (resync)
  );

  tdmc_chain_cap #(
    .N_LOC   (N_LOC),
    .DATA_W  (DATA_W),
    .SLOT_W  (SLOT_W),
    .POS_W   (POS_W),
    .BIT_W   (BIT_W),
    .SLOT_IW (SLOT_IW),
    .CH_W    (CH_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos       (pos),
    .locked    (locked),
    .resync    (resync),
    .chain_in  (chain_in),
    .cap_data  (cap_data),
    .cap_valid (cap_valid)
  );

  tdmc_slot_mux #(
    .N_LOC   (N_LOC),
    .DATA_W  (DATA_W),
    .POS_W   (POS_W),
    .BIT_W   (BIT_W),
    .SLOT_IW (SLOT_IW),
    .CH_W    (CH_W)
  ) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .pos         (pos),
    .locked      (locked),
    .frame_begin (frame_begin),
    .loc_smp     (loc_smp),
    .cap_data    (cap_data),
    .cap_valid   (cap_valid),
    .pri_out     (pri_out),
    .sec_out     (sec_out)
  );

endmodule

// File: tb/tdmc_merge_bench.sv
`timescale 1ns/1ps
module tdmc_merge_bench;

  localparam int SW = 32;
  localparam int DW = 24;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frm_start;
  logic [95:0]   loc_smp;
  logic          chain_in;
  logic          pri_out;
  logic          sec_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tdmc_merge u_tdmc_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_start (frm_start),
    .loc_smp   (loc_smp),
    .chain_in  (chain_in),
    .pri_out   (pri_out),
    .sec_out   (sec_out)
  );

  // Expected primary bit at frame position k.
  function automatic logic exp_pri(input logic [95:0] loc, input logic [95:0] ups, input int k);
    int s = k / SW;
    int b = k % SW;
    if (b >= DW) return 1'b0;
    if (s < NL)  return loc[7'(s*DW + DW-1 - b)];
    return ups[7'((s-NL)*DW + DW-1 - b)];
  endfunction

  function automatic logic exp_sec(input logic [95:0] loc, input int k);
    int s = k / SW;
    int b = k % SW;
    if (b >= DW || s >= NL) return 1'b0;
    return loc[7'(s*DW + DW-1 - b)];
  endfunction

  // Stream placed on the chain input: real data where it is captured, junk elsewhere.
  function automatic logic chain_bit(input logic [95:0] ups, input int k);
    int s = k / SW;
    int b = k % SW;
    if (s < NL && b < DW) return ups[7'(s*DW + DW-1 - b)];
    return 1'(((k * 29) >> 2) & 1);
  endfunction

  task automatic check_one(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle_quiet(input int n, input string tag);
    int bad = 0;
    logic first_act = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((pri_out | sec_out) !== 1'b0 && bad == 0) first_act = pri_out | sec_out;
      if ((pri_out | sec_out) !== 1'b0) bad++;
      chain_in = 1'(i & 1);
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: outputs active %0d times, got %b expected 0", tag, bad, first_act);
    end
  endtask

  // Runs len positions of a frame; caller is just past a negedge.
  task automatic run_frame(input logic [95:0] loc, input logic [95:0] ups, input int len,
                           input bit use_sync, input int chg_at, input string tag);
    int bad_p = 0, bad_s = 0, kp = -1, ks = -1;
    logic ap = 1'b0, ep = 1'b0, as_ = 1'b0, es = 1'b0;
    loc_smp   = loc;
    frm_start = use_sync;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      frm_start = 1'b0;
      if (k == chg_at) loc_smp = ~loc;
      if (pri_out !== exp_pri(loc, ups, k)) begin
        if (bad_p == 0) begin kp = k; ap = pri_out; ep = exp_pri(loc, ups, k); end
        bad_p++;
      end
      if (sec_out !== exp_sec(loc, k)) begin
        if (bad_s == 0) begin ks = k; as_ = sec_out; es = exp_sec(loc, k); end
        bad_s++;
      end
      chain_in = chain_bit(ups, k);
    end
    checks += 2;
    if (bad_p != 0) begin
      errors++;
      $display("FAIL %s pri_out pos %0d (%0d bad): got %b expected %b", tag, kp, bad_p, ap, ep);
    end
    if (bad_s != 0) begin
      errors++;
      $display("FAIL %s sec_out pos %0d (%0d bad): got %b expected %b", tag, ks, bad_s, as_, es);
    end
  endtask

  initial begin
    #(5.0 * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_start = 1'b0; chain_in = 1'b0; loc_smp = '0;
    repeat (3) @(negedge clk);
    check_one("R8 pri_out in reset", pri_out, 1'b0);
    check_one("R8 sec_out in reset", sec_out, 1'b0);
    rst_n = 1'b1;
    idle_quiet(300, "R8 quiet before first sync");

    run_frame(96'hA5C3F0_123456_789ABC_DEF013, 96'h3C96E1_0F1E2D_B4A597_55AA33, 256, 1, -1,
              "R1 R2 R3 R4 R5 R7 base frame");
    run_frame(96'hFFFFFF_FFFFFF_FFFFFF_FFFFFF, 96'hAAAAAA_555555_AAAAAA_555555, 256, 1, -1,
              "R2 R4 R5 dense frame");
    run_frame(96'h81C3E7_FF7E3C_180042_6699CC, 96'h0000FF_FF0000_00FF00_F0F0F0, 256, 1, 40,
              "R6 local held across frame");
    run_frame(96'h13579B_2468AC_FEDCBA_0F0F0F, 96'h5A5A5A_C0FFEE_BADA55_010203, 256, 0, -1,
              "R9 frame started by wrap");
    run_frame(96'h111111_222222_333333_444444, 96'hDEAD00_BEEF00_CAFE00_F00D00, 60, 1, -1,
              "R10 frame cut at 60");
    run_frame(96'h9ABCDE_F01234_56789A_BCDEF0, 96'h77FF11_22EE33_44DD55_66CC88, 256, 1, -1,
              "R10 frame after early sync");
    run_frame(96'h0C0C0C_F3F3F3_3F3F3F_C0C0C0, 96'h123123_456456_789789_ABCABC, 200, 1, -1,
              "R10 frame cut at 200");
    run_frame(96'h6B6B6B_B6B6B6_E1E1E1_1E1E1E, 96'h0, 256, 1, -1,
              "R4 chain input held low");
    run_frame(96'h000001_800000_000100_010000, 96'h000000_000800_000000_000000, 256, 1, 200,
              "R4 R6 walking one");

    @(negedge clk);
    rst_n = 1'b0; frm_start = 1'b0;
    @(negedge clk);
    check_one("R8 pri_out in mid-run reset", pri_out, 1'b0);
    check_one("R8 sec_out in mid-run reset", sec_out, 1'b0);
    rst_n = 1'b1;
    idle_quiet(100, "R8 quiet after mid-run reset");
    run_frame(96'hA5C3F0_123456_789ABC_DEF013, 96'hAAAAAA_555555_AAAAAA_555555, 256, 1, -1,
              "R1 R2 R4 restart after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule